// File: doc/BRIEF.md
# Performance Counter Overflow Interrupt Unit

This block keeps a small set of event counters, 32 bits each in the default build, and a mode control register. Each cycle, an increment input per counter adds one to that counter. When an increment takes a counter from a non-negative value to a negative one (its most significant bit goes from 0 to 1), and the control register enables that counter as an interrupt source, a sticky pending bit is set. The pending bit stays set while interrupts are disabled. It clears only when the interrupt is acknowledged or when software writes the control register.

The interrupt request is the pending bit gated by the external-interrupt enable from the machine state. A fixed vector offset of 0x00F00 comes with the request. Software loads the counters and the control register through a write port. It reads any of them back through a combinational read port.

The write port uses a valid/ready handshake, but it never applies back-pressure. `wr_ready` is held high out of reset, so every cycle in which `wr_valid` is high completes a write. All other pins are plain control and status signals.

Top module: `pmon_irq_unit`

## Requirements
- R1: During and after reset, every counter reads 0, the control register reads 0, the pending bit is clear, and `irq_req` is low.
- R2: A counter whose `evt_inc` bit is high at a rising edge, and which is not written in that cycle, holds its old value plus one after that edge. A counter with neither an increment nor a write keeps its value.
- R3: Write address 1 loads counter 0 and write address 2 loads counter 1 from `wr_data`. A write to a counter wins over an increment to the same counter in the same cycle.
- R4: Write address 0 loads the control register. Bit i of the control register enables counter i as an interrupt source. Reading address 0 returns the enable bits in the low bits and zeros above them. Reads use `rd_addr` combinationally, and unused addresses read 0.
- R5: The pending bit sets at the edge where an increment moves an enabled counter from a value with MSB 0 to a value with MSB 1, for example 0x7FFFFFFF to 0x80000000.
- R6: The same crossing on a counter whose enable bit is 0 leaves the pending bit unchanged.
- R7: A write that loads a value with MSB 1 never sets the pending bit, including when the counter held a value with MSB 0 before the write.
- R8: The pending bit stays set while `ee` is low. `irq_req` equals the pending bit ANDed with `ee` in the same cycle, so `irq_req` rises as soon as `ee` rises.
- R9: An `irq_ack`, or any write to address 0, clears the pending bit at the next edge. A new crossing in that same cycle keeps the pending bit set.
- R10: `irq_vector` always reads 0x00F00.
- R11: An increment that wraps a counter from 0xFFFFFFFF to 0 does not set the pending bit.
- R12: `wr_ready` is high in every cycle after reset is released, so a write is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always high after reset) |
| wr_addr | input | ADDR_W (2) | Write address: 0 control, 1 counter 0, 2 counter 1 |
| wr_data | input | CNT_W (32) | Write data |
| rd_addr | input | ADDR_W (2) | Read address, same map as the write address |
| rd_data | output | CNT_W (32) | Combinational read data |
| evt_inc | input | NUM_CNT (2) | Per-counter increment, one bit per counter |
| ee | input | 1 | External-interrupt enable from the machine state |
| irq_ack | input | 1 | Interrupt taken, clears the pending bit |
| irq_req | output | 1 | Interrupt request, equal to pending AND ee |
| irq_vector | output | VEC_W (20) | Fixed vector offset 0x00F00 |

## Verification
Counter values, the control register and the pending bit are registered. Their effect on `rd_data` and `irq_req` becomes visible one rising edge after the write, increment, crossing, acknowledge or control write that caused it. `irq_req` follows a change of `ee` combinationally, and `rd_data` follows a change of `rd_addr` combinationally.

The bench drives each cycle's inputs and then waits for the rising edge. It advances its reference model by that same edge and compares all outputs 2 ns later. Where `ee` or `rd_addr` is changed between edges, it compares again after a short settle, without any clock edge in between.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned PMON_CTRL_ADDR  = 0;
  localparam int unsigned PMON_VEC_OFFSET = 32'h0000_0F00;

  function automatic int unsigned cnt_addr(input int unsigned idx);
    return idx + 1;
  endfunction
endpackage

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             went_neg
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] inc_val;

  assign inc_val = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= inc_val;
  end

  // Only an increment can produce a 0->1 sign transition; loads never do.
  assign went_neg = !ld && inc && !cnt_q[MSB] && inc_val[MSB];
  assign cnt      = cnt_q;

  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && inc) |=> cnt == $past(cnt) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(cnt));
  p_wrap_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[MSB] && inc) |-> !went_neg);
endmodule

// File: rtl/pmon_reg_if.sv
module pmon_reg_if
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
  output logic [NUM_CNT-1:0]            cnt_ld,
  output logic [NUM_CNT-1:0]            src_en,
  output logic                          ctrl_wr,
  output logic [CNT_W-1:0]              rd_data
);
  logic [NUM_CNT-1:0] ctrl_q;

  assign ctrl_wr = wr_valid && (wr_addr == ADDR_W'(PMON_CTRL_ADDR));

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_ld
    assign cnt_ld[gi] = wr_valid && (wr_addr == ADDR_W'(cnt_addr(gi)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data[NUM_CNT-1:0];
  end

  assign src_en = ctrl_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(PMON_CTRL_ADDR)) rd_data[NUM_CNT-1:0] = ctrl_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_addr == ADDR_W'(cnt_addr(i))) rd_data = cnt_all[i];
    end
  end

  p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> src_en == $past(wr_data[NUM_CNT-1:0]));
  p_ld_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_ld, ctrl_wr}));
endmodule

// File: rtl/pmon_pending.sv
module pmon_pending #(
  parameter int NUM_CNT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] went_neg,
  input  logic [NUM_CNT-1:0] src_en,
  input  logic               clr,
  output logic               pending
);
  logic set;
  logic pend_q;

  assign set = |(went_neg & src_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q && !clr) || set;
  end

  assign pending = pend_q;

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pending);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pending);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !set) |=> !pending);
endmodule

// File: rtl/pmon_irq_unit.sv
module pmon_irq_unit
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 2,
  parameter int VEC_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  input  logic [NUM_CNT-1:0] evt_inc,
  input  logic               ee,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vector
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            cnt_ld;
  logic [NUM_CNT-1:0]            went_neg;
  logic [NUM_CNT-1:0]            src_en;
  logic                          ctrl_wr;
  logic                          pending;

  pmon_reg_if #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt_all(cnt_all),
    .cnt_ld(cnt_ld), .src_en(src_en), .ctrl_wr(ctrl_wr), .rd_data(rd_data)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    pmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .ld(cnt_ld[gi]), .ld_val(wr_data), .inc(evt_inc[gi]),
      .cnt(cnt_all[gi]), .went_neg(went_neg[gi])
    );
  end

  pmon_pending #(.NUM_CNT(NUM_CNT)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .went_neg(went_neg), .src_en(src_en),
    .clr(irq_ack || ctrl_wr), .pending(pending)
  );

  assign wr_ready   = 1'b1;
  assign irq_req    = pending && ee;
  assign irq_vector = VEC_W'(PMON_VEC_OFFSET);

  p_ee_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ee |-> !irq_req);
  p_load_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !(|(evt_inc & ~cnt_ld))) |=> !pending);
endmodule

// File: tb/pmon_irq_unit_test.sv
`timescale 1ns/1ps
module pmon_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  evt_inc = '0;
  logic        ee = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [19:0] irq_vector;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt [2];
  logic [1:0]  m_ctrl;
  bit          m_pend;

  always #4 clk = ~clk;

  pmon_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_inc(evt_inc), .ee(ee), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] a);
    if (a == 2'd0) return {30'd0, m_ctrl};
    if (a == 2'd1) return m_cnt[0];
    if (a == 2'd2) return m_cnt[1];
    return 32'd0;
  endfunction

  task automatic compare_all(input string tag);
    chk({tag, " rd_data"}, rd_data, m_read(rd_addr));
    chk({tag, " irq_req"}, {31'd0, irq_req}, {31'd0, m_pend && ee});
    chk("R10 irq_vector", {12'd0, irq_vector}, 32'h0000_0F00);
    chk("R12 wr_ready", {31'd0, wr_ready}, 32'd1);
  endtask

  // One clock: drive, advance model with the edge, compare 2 ns later.
  task automatic cyc(input bit wv, input logic [1:0] wa, input logic [31:0] wd,
                     input logic [1:0] inc, input bit ack, input bit e,
                     input logic [1:0] ra, input string tag);
    bit set;
    bit clr;
    logic [31:0] nxt;
    wr_valid = wv; wr_addr = wa; wr_data = wd; evt_inc = inc;
    irq_ack = ack; ee = e; rd_addr = ra;
    @(posedge clk);
    set = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (wv && wa == 2'(i + 1)) m_cnt[i] = wd;
      else if (inc[i]) begin
        nxt = m_cnt[i] + 32'd1;
        if (!m_cnt[i][31] && nxt[31] && m_ctrl[i]) set = 1'b1;
        m_cnt[i] = nxt;
      end
    end
    clr = ack || (wv && wa == 2'd0);
    m_pend = (m_pend && !clr) || set;
    if (wv && wa == 2'd0) m_ctrl = wd[1:0];
    #2;
    compare_all(tag);
  endtask

  task automatic look(input logic [1:0] ra, input bit e, input string tag);
    rd_addr = ra; ee = e;
    #1;
    compare_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    m_cnt[0] = '0; m_cnt[1] = '0; m_ctrl = '0; m_pend = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    for (int a = 0; a < 4; a++) look(2'(a), 1'b1, "R1 reset");
    rst_n = 1'b1;
    cyc(0, 0, 0, 2'b00, 0, 1, 1, "R1 after reset");

    // R2: increments
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 2'b01, 0, 0, 1, "R2 count a");
    cyc(0, 0, 0, 2'b10, 0, 0, 2, "R2 count b");
    cyc(0, 0, 0, 2'b00, 0, 0, 1, "R2 hold");

    // R3: write beats increment
    cyc(1, 1, 32'h1234_0000, 2'b11, 0, 0, 1, "R3 write vs inc");
    cyc(0, 0, 0, 2'b00, 0, 0, 2, "R3 other counter");
    cyc(1, 2, 32'hABCD_0001, 2'b00, 0, 0, 2, "R3 write b");

    // R4: control write and readback, unused address
    cyc(1, 0, 32'hFFFF_FFFF, 2'b00, 0, 0, 0, "R4 ctrl readback");
    look(3, 0, "R4 unused addr");

    // R5 / R8: crossing while ee low, then ee rises
    cyc(1, 1, 32'h7FFF_FFFE, 2'b00, 0, 0, 1, "R5 preload");
    cyc(0, 0, 0, 2'b01, 0, 0, 1, "R5 no cross yet");
    cyc(0, 0, 0, 2'b01, 0, 0, 1, "R5 crossing");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 2'b00, 0, 0, 1, "R8 sticky masked");
    look(1, 1, "R8 ee rises");
    cyc(0, 0, 0, 2'b00, 0, 1, 1, "R8 request held");

    // R9: ack clears
    cyc(0, 0, 0, 2'b00, 1, 1, 1, "R9 ack clears");

    // R6: disabled source
    cyc(1, 0, 32'h0000_0001, 2'b00, 0, 1, 0, "R6 enable only a");
    cyc(1, 2, 32'h7FFF_FFFF, 2'b00, 0, 1, 2, "R6 preload b");
    cyc(0, 0, 0, 2'b10, 0, 1, 2, "R6 disabled crossing");

    // R7: negative load
    cyc(1, 0, 32'h0000_0003, 2'b00, 0, 1, 0, "R7 enable both");
    cyc(1, 1, 32'h0000_0005, 2'b00, 0, 1, 1, "R7 positive load");
    cyc(1, 1, 32'h8000_0005, 2'b01, 0, 1, 1, "R7 negative load");
    cyc(0, 0, 0, 2'b00, 0, 1, 1, "R7 still clear");

    // R11: wrap
    cyc(1, 2, 32'hFFFF_FFFF, 2'b00, 0, 1, 2, "R11 preload");
    cyc(0, 0, 0, 2'b10, 0, 1, 2, "R11 wrap to zero");

    // R9: crossing in same cycle as ack, then ctrl write clears
    cyc(1, 1, 32'h7FFF_FFFF, 2'b00, 0, 1, 1, "R9 preload");
    cyc(0, 0, 0, 2'b01, 1, 1, 1, "R9 set beats ack");
    cyc(1, 0, 32'h0000_0003, 2'b00, 0, 1, 0, "R9 ctrl write clears");

    // Mixed traffic near the sign boundary
    for (int k = 0; k < 400; k++) begin
      bit wv;
      logic [1:0] wa;
      logic [31:0] wd;
      wv = ($urandom_range(0, 3) == 0);
      wa = 2'($urandom_range(0, 2));
      wd = (wa == 2'd0) ? 32'($urandom_range(0, 3))
                        : 32'h7FFF_FFF0 + 32'($urandom_range(0, 31));
      cyc(wv, wa, wd, 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 1) == 1), 2'($urandom_range(0, 3)), "R5 mixed");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule